// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block stands between a host's memory strobes and a battery-backed static memory. It watches two supply comparator flags, which are already digitized and filtered. The first says the supply is above the deselect threshold. The second says it is above the lower battery switchover threshold. From these two flags the block sequences the memory through five phases:

- guarded (protected)
- running on the backup cell
- a hold-off period after the supply returns
- normal operation
- an optional deferred-deselect window, which models a supply that falls faster than the detector can follow

During normal operation the host's chip-enable, output-enable and write-enable requests are decoded and passed on as registered memory strobes. In every other phase they are blocked. The block also drives a backup-select line, a ready flag and a three-bit phase code.

The hold-off after power returns counts `REC_CYCLES` clock cycles. The deferred window counts `LATE_CYCLES` cycles; setting it to zero removes that path. A write that is cut short by a supply loss is not resumed when the supply returns. The host must first release its write or chip strobe before another write is granted.

Top module: `pwr_guard_top`

## Requirements
- R1: When `supply_ok_i` is low at a clock edge in normal phase and `fast_fall_i` is low, the outputs after that edge show `ready_o`=0, `mem_ce_n_o`=1 and `mem_we_n_o`=1.
- R2: In the guarded (code 0), backup (code 1) and hold-off (code 2) phases, the outputs are `mem_ce_n_o`=1, `mem_we_n_o`=1 and `drive_o`=0, whatever the request inputs are.
- R3: `supply_live_i` low at an edge gives `bat_sel_o`=1 and phase code 1 after it. `supply_live_i` high in backup phase returns the block to the guarded phase, with `bat_sel_o`=0.
- R4: The guarded phase with `supply_ok_i` high enters hold-off (code 2). Hold-off lasts exactly `REC_CYCLES` cycles. The block then enters normal phase (code 3).
- R5: `supply_ok_i` low during hold-off returns the block to the guarded phase. A later hold-off runs the full `REC_CYCLES` again.
- R6: If `supply_ok_i` drops in normal phase while `fast_fall_i` is high (and `LATE_CYCLES`>0), the block holds deferred phase (code 4) for `LATE_CYCLES` cycles. Requests are still decoded there, with `ready_o`=0. The block then enters the guarded phase.
- R7: A write request held low across an outage is not granted on return to normal phase. `mem_we_n_o` stays 1 until `we_n_i` or `ce_n_i` has been high for at least one cycle.
- R8: In normal phase, the request inputs are decoded as follows:
  - `ce_n_i`=1: deselects.
  - `ce_n_i`=0 with `we_n_i`=0: a write (`mem_ce_n_o`=0, `mem_we_n_o`=0, `drive_o`=0).
  - `ce_n_i`=0, `oe_n_i`=0, `we_n_i`=1: a read (`drive_o`=1).
  - `ce_n_i`=0, `oe_n_i`=1, `we_n_i`=1: `drive_o`=0.
- R9: Synchronous reset puts the block in the guarded phase (code 0) with all strobes inactive and `bat_sel_o`=0. The block stays there while `supply_ok_i` is low.
- R10: `ready_o` is 1 only in normal phase (code 3). All outputs are registered and follow their inputs by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply above deselect threshold |
| supply_live_i | input | 1 | Supply above battery switchover threshold |
| fast_fall_i | input | 1 | Supply is falling faster than the minimum fall time |
| ce_n_i | input | 1 | Host chip enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| mem_ce_n_o | output | 1 | Gated memory chip enable, active low |
| mem_we_n_o | output | 1 | Gated memory write enable, active low |
| drive_o | output | 1 | Data output drive enable |
| bat_sel_o | output | 1 | Select backup cell as memory supply |
| ready_o | output | 1 | Normal access allowed |
| state_o | output | 3 | Phase code: 0 guarded, 1 backup, 2 hold-off, 3 normal, 4 deferred |

## Verification
The hardest situations to reach are a supply dip in the middle of the hold-off period and a write strobe held low across a whole outage. Both depend on the exact cycle at which a flag changes relative to the internal timer. The bench takes the block to normal phase, drops the flag, restores it, and drops it again a few cycles into hold-off. It then counts a full hold-off afterwards. For the write case, it asserts a write, removes and restores the supply while keeping the strobes low, and checks that no write is granted until the strobe is toggled.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef enum logic [2:0] {
    PH_GUARD   = 3'd0,
    PH_BACKUP  = 3'd1,
    PH_HOLDOFF = 3'd2,
    PH_RUN     = 3'd3,
    PH_DEFER   = 3'd4
  } pg_phase_e;

  function automatic int unsigned pg_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pg_cycle_timer.sv
module pg_cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last = limit - W'(1);
  assign done = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/pg_phase_fsm.sv
module pg_phase_fsm
  import pwr_guard_pkg::*;
#(
  parameter int unsigned REC_CYCLES  = 500000,
  parameter int unsigned LATE_CYCLES = 50000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      supply_ok_i,
  input  logic      supply_live_i,
  input  logic      fast_fall_i,
  output pg_phase_e phase_d
);

  localparam int unsigned MAXC = pg_max(REC_CYCLES, LATE_CYCLES);
  localparam int unsigned TW   = $clog2(MAXC + 1);
  localparam bit HAS_DEFER     = (LATE_CYCLES > 0);

  pg_phase_e      phase_q;
  logic [TW-1:0]  limit;
  logic           tmr_done;
  logic           tmr_clr;
  logic           counting;

  generate
    if (HAS_DEFER) begin : g_two_limits
      assign limit = (phase_q == PH_DEFER) ? TW'(LATE_CYCLES) : TW'(REC_CYCLES);
    end else begin : g_one_limit
      assign limit = TW'(REC_CYCLES);
    end
  endgenerate

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_GUARD: begin
        if (!supply_live_i)   phase_d = PH_BACKUP;
        else if (supply_ok_i) phase_d = PH_HOLDOFF;
      end
      PH_BACKUP: begin
        if (supply_live_i) phase_d = PH_GUARD;
      end
      PH_HOLDOFF: begin
        if (!supply_live_i)    phase_d = PH_BACKUP;
        else if (!supply_ok_i) phase_d = PH_GUARD;
        else if (tmr_done)     phase_d = PH_RUN;
      end
      PH_RUN: begin
        if (!supply_live_i) phase_d = PH_BACKUP;
        else if (!supply_ok_i) begin
          if (fast_fall_i && HAS_DEFER) phase_d = PH_DEFER;
          else                          phase_d = PH_GUARD;
        end
      end
      PH_DEFER: begin
        if (!supply_live_i) phase_d = PH_BACKUP;
        else if (tmr_done)  phase_d = PH_GUARD;
      end
      default: phase_d = PH_GUARD;
    endcase
  end

  assign counting = (phase_q == PH_HOLDOFF) || (phase_q == PH_DEFER);
  assign tmr_clr  = !counting || (phase_d != phase_q);

  pg_cycle_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .limit (limit),
    .done  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_GUARD;
    else     phase_q <= phase_d;
  end

endmodule

// File: rtl/pg_access_gate.sv
module pg_access_gate
  import pwr_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pg_phase_e  phase_d,
  input  logic       ce_n_i,
  input  logic       oe_n_i,
  input  logic       we_n_i,
  output logic       mem_ce_n_o,
  output logic       mem_we_n_o,
  output logic       drive_o,
  output logic       bat_sel_o,
  output logic       ready_o,
  output logic [2:0] state_o
);

  logic open_d;
  logic armed_q;
  logic armed_d;
  logic wr_d;
  logic rd_d;

  always_comb begin
    open_d  = (phase_d == PH_RUN) || (phase_d == PH_DEFER);
    armed_d = open_d && (we_n_i || ce_n_i || armed_q);
    wr_d    = open_d && !ce_n_i && !we_n_i && armed_d;
    rd_d    = open_d && !ce_n_i && !oe_n_i && we_n_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      mem_ce_n_o <= 1'b1;
      mem_we_n_o <= 1'b1;
      drive_o    <= 1'b0;
      bat_sel_o  <= 1'b0;
      ready_o    <= 1'b0;
      state_o    <= PH_GUARD;
    end else begin
      armed_q    <= armed_d;
      mem_ce_n_o <= !(open_d && !ce_n_i);
      mem_we_n_o <= !wr_d;
      drive_o    <= rd_d;
      bat_sel_o  <= (phase_d == PH_BACKUP);
      ready_o    <= (phase_d == PH_RUN);
      state_o    <= phase_d;
    end
  end

endmodule

// File: rtl/pwr_guard_top.sv
module pwr_guard_top
  import pwr_guard_pkg::*;
#(
  parameter int unsigned REC_CYCLES  = 500000,
  parameter int unsigned LATE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       supply_live_i,
  input  logic       fast_fall_i,
  input  logic       ce_n_i,
  input  logic       oe_n_i,
  input  logic       we_n_i,
  output logic       mem_ce_n_o,
  output logic       mem_we_n_o,
  output logic       drive_o,
  output logic       bat_sel_o,
  output logic       ready_o,
  output logic [2:0] state_o
);

  pg_phase_e phase_d;

  pg_phase_fsm #(
    .REC_CYCLES  (REC_CYCLES),
    .LATE_CYCLES (LATE_CYCLES)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .supply_ok_i   (supply_ok_i),
    .supply_live_i (supply_live_i),
    .fast_fall_i   (fast_fall_i),
    .phase_d       (phase_d)
  );

  pg_access_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .phase_d    (phase_d),
    .ce_n_i     (ce_n_i),
    .oe_n_i     (oe_n_i),
    .we_n_i     (we_n_i),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_we_n_o (mem_we_n_o),
    .drive_o    (drive_o),
    .bat_sel_o  (bat_sel_o),
    .ready_o    (ready_o),
    .state_o    (state_o)
  );

endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter int unsigned REC_CYCLES  = 500000,
  parameter int unsigned LATE_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok_i,
  input logic       supply_live_i,
  input logic       fast_fall_i,
  input logic       mem_ce_n_o,
  input logic       mem_we_n_o,
  input logic       drive_o,
  input logic       bat_sel_o,
  input logic       ready_o,
  input logic [2:0] state_o
);

  int unsigned hold_cnt;

  always_ff @(posedge clk) begin
    if (rst)                hold_cnt <= 0;
    else if (state_o == 3'd2) hold_cnt <= hold_cnt + 1;
    else                    hold_cnt <= 0;
  end

  assert_drop_blocks_R1: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !supply_ok_i && !fast_fall_i) |=> (!ready_o && mem_we_n_o && mem_ce_n_o));

  assert_guard_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o <= 3'd2) |-> (mem_ce_n_o && mem_we_n_o && !drive_o));

  assert_backup_enter_R3: assert property (@(posedge clk) disable iff (rst)
    !supply_live_i |=> bat_sel_o);

  assert_backup_leave_R3: assert property (@(posedge clk) disable iff (rst)
    (bat_sel_o && supply_live_i) |=> (!bat_sel_o && state_o == 3'd0));

  assert_holdoff_len_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (hold_cnt == REC_CYCLES));

  assert_holdoff_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && !supply_ok_i && supply_live_i) |=> (state_o == 3'd0));

  generate
    if (LATE_CYCLES > 0) begin : g_defer_chk
      assert_defer_enter_R6: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !supply_ok_i && fast_fall_i && supply_live_i) |=> (state_o == 3'd4));
    end
  endgenerate

  assert_no_resume_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> mem_we_n_o);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> (!mem_ce_n_o && mem_we_n_o));

  assert_ready_run_R10: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!bat_sel_o && state_o == 3'd3));

endmodule

bind pwr_guard_top pwr_guard_chk #(
  .REC_CYCLES  (REC_CYCLES),
  .LATE_CYCLES (LATE_CYCLES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .supply_ok_i   (supply_ok_i),
  .supply_live_i (supply_live_i),
  .fast_fall_i   (fast_fall_i),
  .mem_ce_n_o    (mem_ce_n_o),
  .mem_we_n_o    (mem_we_n_o),
  .drive_o       (drive_o),
  .bat_sel_o     (bat_sel_o),
  .ready_o       (ready_o),
  .state_o       (state_o)
);

// File: tb/pwr_guard_top_tb.sv
`timescale 1ns/1ps
module pwr_guard_top_tb;

  localparam int unsigned REC  = 12;
  localparam int unsigned LATE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ok = 1'b0, live = 1'b1, fast = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic mce_n, mwe_n, drv, bat, rdy;
  logic [2:0] st;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_guard_top #(.REC_CYCLES(REC), .LATE_CYCLES(LATE)) u_dut (
    .clk(clk), .rst(rst), .supply_ok_i(ok), .supply_live_i(live), .fast_fall_i(fast),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .mem_ce_n_o(mce_n), .mem_we_n_o(mwe_n), .drive_o(drv),
    .bat_sel_o(bat), .ready_o(rdy), .state_o(st)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobes_idle(input string req);
    check(req, "mem_ce_n", mce_n, 1);
    check(req, "mem_we_n", mwe_n, 1);
    check(req, "drive", drv, 0);
  endtask

  task automatic bring_up();
    ce_n = 1; oe_n = 1; we_n = 1; fast = 0; live = 1; ok = 1;
    step(REC + 1);
    check("R4", "ready after holdoff", rdy, 1);
  endtask

  task automatic t_reset();
    ok = 0; live = 1; ce_n = 0; we_n = 0; oe_n = 0;
    step(3);
    rst = 0;
    check("R9", "state in reset", st, 0);
    check("R9", "bat_sel in reset", bat, 0);
    strobes_idle("R9");
    step(4);
    check("R9", "stays guarded", st, 0);
    strobes_idle("R2");
    check("R10", "ready low", rdy, 0);
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic t_holdoff();
    ok = 1;
    step(1);
    check("R4", "enter holdoff", st, 2);
    ce_n = 0; oe_n = 0;
    step(REC - 1);
    check("R4", "last holdoff cycle", st, 2);
    check("R10", "ready during holdoff", rdy, 0);
    strobes_idle("R2");
    ce_n = 1; oe_n = 1;
    step(1);
    check("R4", "normal after holdoff", st, 3);
    check("R10", "ready in normal", rdy, 1);
  endtask

  task automatic t_decode();
    ce_n = 1; oe_n = 0; we_n = 0; step(1);
    check("R8", "deselect ce", mce_n, 1);
    check("R8", "deselect we", mwe_n, 1);
    ce_n = 1; we_n = 1; step(1);
    ce_n = 0; oe_n = 1; we_n = 0; step(1);
    check("R8", "write ce", mce_n, 0);
    check("R8", "write we", mwe_n, 0);
    check("R8", "write drive", drv, 0);
    ce_n = 0; oe_n = 0; we_n = 1; step(1);
    check("R8", "read drive", drv, 1);
    check("R8", "read we", mwe_n, 1);
    ce_n = 0; oe_n = 1; we_n = 1; step(1);
    check("R8", "idle drive", drv, 0);
    check("R8", "idle ce", mce_n, 0);
    ce_n = 1;
  endtask

  task automatic t_write_abort();
    ce_n = 0; we_n = 0; step(1);
    check("R7", "write granted", mwe_n, 0);
    ok = 0; step(1);
    check("R1", "ready drop", rdy, 0);
    check("R1", "we cut", mwe_n, 1);
    check("R1", "ce cut", mce_n, 1);
    ok = 1; step(REC + 1);
    check("R4", "back to normal", rdy, 1);
    check("R7", "held write not resumed", mwe_n, 1);
    step(2);
    check("R7", "still blocked", mwe_n, 1);
    we_n = 1; step(1);
    check("R7", "released", mwe_n, 1);
    we_n = 0; step(1);
    check("R7", "new write granted", mwe_n, 0);
    ce_n = 1; we_n = 1; step(1);
  endtask

  task automatic t_holdoff_abort();
    ok = 0; step(1);
    check("R1", "guarded", st, 0);
    ok = 1; step(5);
    check("R5", "in holdoff", st, 2);
    ok = 0; step(1);
    check("R5", "back to guard", st, 0);
    ok = 1; step(REC);
    check("R5", "full holdoff rerun", st, 2);
    step(1);
    check("R5", "normal after rerun", rdy, 1);
  endtask

  task automatic t_backup();
    ok = 0; live = 0; ce_n = 0; oe_n = 0; step(1);
    check("R3", "backup phase", st, 1);
    check("R3", "bat_sel on", bat, 1);
    strobes_idle("R2");
    step(3);
    check("R3", "bat_sel held", bat, 1);
    live = 1; step(1);
    check("R3", "bat_sel off", bat, 0);
    check("R3", "guarded after backup", st, 0);
    ce_n = 1; oe_n = 1;
    bring_up();
  endtask

  task automatic t_defer();
    ce_n = 0; oe_n = 0; we_n = 1; step(1);
    fast = 1; ok = 0; step(1);
    check("R6", "deferred phase", st, 4);
    check("R6", "read still passes", drv, 1);
    check("R10", "ready low deferred", rdy, 0);
    step(LATE - 1);
    check("R6", "deferred last cycle", st, 4);
    step(1);
    check("R6", "guard after defer", st, 0);
    check("R6", "drive cut", drv, 0);
    fast = 0; ce_n = 1; oe_n = 1;
    bring_up();
  endtask

  initial begin
    step(100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_holdoff();
    t_decode();
    t_write_abort();
    t_holdoff_abort();
    t_backup();
    t_defer();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule